// File: doc/BRIEF.md
# Channel Command Sequencer

This block holds the command byte that a host writes for one serial channel. The host sets one or more request bits in a single write. The block latches the byte and works through the requested actions one per clock cycle, always in the same priority order. Each action raises a one-cycle strobe toward the logic that performs it: FIFO and status clearing, protocol-register initialisation, the receiver enable and disable, the transmitter enable and disable, and a global reset.

While the actions are still being carried out, the register reads back the byte that was written. On the clock edge that follows the last strobe it returns to zero. A host that reads zero therefore knows the block is ready for the next command.

The block also keeps two flags, one showing whether the transmitter is enabled and one showing whether the receiver is enabled. A sticky error flag records any attempt to write while a command is still in progress.

Top module: `chan_cmd_seq`

## Requirements
- R1: After synchronous reset the command readback is 0x00, the transmit-enabled, receive-enabled and error flags are 0, and no strobe is active.
- R2: A write while the readback is zero, with bit 7 clear and at least one other bit set, shows the written byte on the readback from the next cycle until the command completes. A write of 0x00 has no effect.
- R3: A write with bit 7 set while idle is dropped. The readback stays 0x00, no strobe fires, and the flags are unchanged.
- R4: Each requested action produces exactly one strobe lasting one cycle. At most one strobe is active in any cycle. Requested actions follow one another on consecutive cycles, and actions that were not requested take no cycle.
- R5: The command bits are bit 6 clear channel, bit 5 initialise, bit 4 reset all, bit 3 transmit enable, bit 2 transmit disable, bit 1 receive enable and bit 0 receive disable. The actions run in this order: clear, initialise, receive enable, receive disable, transmit enable, transmit disable.
- R6: When bit 4 is set, every other bit of that write is ignored. Only the reset-all strobe fires. It clears both enable flags and the error flag, and the readback returns to zero on the next cycle.
- R7: The readback returns to 0x00 on the clock edge that ends the cycle of the last strobe.
- R8: The clear-channel action leaves both the transmit-enabled and the receive-enabled flags at 0.
- R9: An enable action sets its direction's flag and a disable action clears it. When both are requested for the same direction, the disable action runs later, so the flag ends at 0.
- R10: A write while the readback is non-zero is ignored: the running command and its strobes continue unchanged. The write sets the sticky error flag. If it coincides with a reset-all strobe, the flag still ends set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the command byte |
| wr_data | input | 8 | Command byte being written |
| cmd_rd | output | 8 | Command readback; zero when ready |
| wr_err | output | 1 | Sticky flag for a write made while busy |
| tx_enabled | output | 1 | Transmitter enabled status |
| rx_enabled | output | 1 | Receiver enabled status |
| stb_clr | output | 1 | Clear FIFOs, channel status and DMA status |
| stb_init | output | 1 | Reset protocol-specific registers |
| stb_rst_all | output | 1 | Global reset pulse |
| stb_tx_en | output | 1 | Transmitter enable pulse |
| stb_tx_dis | output | 1 | Transmitter disable pulse |
| stb_rx_en | output | 1 | Receiver enable pulse |
| stb_rx_dis | output | 1 | Receiver disable pulse |

## Verification
The hardest case to reach from the ports is a second write that lands during the very cycle of a reset-all strobe, or during the last strobe of a longer command. Landing there needs exact knowledge of how long the command runs. The bench computes the expected strobe sequence for every byte it writes. It then drives a colliding write at chosen positions within that sequence: the first cycle of the reset-all case, or an arbitrary strobe of a random command. It checks the outcome strobe by strobe, and also checks the error flag and the readback once the command has finished.

// File: rtl/chan_cmd_pkg.sv
package chan_cmd_pkg;

    localparam int CMD_W = 8;
    localparam int ACT_W = CMD_W - 1;
    localparam int NUM_ACT = ACT_W;

    // command bit positions (decoded by neighbouring software)
    localparam int B_CTRL   = 7;
    localparam int B_CLR    = 6;
    localparam int B_INIT   = 5;
    localparam int B_RSTALL = 4;
    localparam int B_TXEN   = 3;
    localparam int B_TXDIS  = 2;
    localparam int B_RXEN   = 1;
    localparam int B_RXDIS  = 0;

    typedef logic [ACT_W-1:0] act_mask_t;

    // execution order, highest priority first
    localparam int PRIO [NUM_ACT] = '{B_RSTALL, B_CLR, B_INIT, B_RXEN, B_RXDIS, B_TXEN, B_TXDIS};

    typedef struct packed {
        logic tx_en;
        logic rx_en;
    } chan_flags_t;

    // reset-all overrides everything else in the same write
    function automatic act_mask_t load_mask(input act_mask_t req);
        act_mask_t m;
        m = req;
        if (req[B_RSTALL]) begin
            m = '0;
            m[B_RSTALL] = 1'b1;
        end
        return m;
    endfunction

    // one-hot pick of the highest-priority pending action
    function automatic act_mask_t pick_next(input act_mask_t pend);
        act_mask_t m;
        logic found;
        m = '0;
        found = 1'b0;
        for (int i = 0; i < NUM_ACT; i++) begin
            if (!found && pend[PRIO[i]]) begin
                m[PRIO[i]] = 1'b1;
                found = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/ccs_cmd_reg.sv
module ccs_cmd_reg
    import chan_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CMD_W-1:0] wr_data,
    input  act_mask_t        cur_act,
    output logic [CMD_W-1:0] cmd_q,
    output act_mask_t        pend_q,
    output logic             err_q
);

    logic      busy;
    logic      accept;
    act_mask_t pend_nxt;

    assign busy     = |cmd_q;
    assign accept   = wr_en && !busy && !wr_data[B_CTRL] && (|wr_data[ACT_W-1:0]);
    assign pend_nxt = pend_q & ~cur_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            pend_q <= '0;
        end else if (accept) begin
            cmd_q  <= wr_data;
            pend_q <= load_mask(wr_data[ACT_W-1:0]);
        end else if (busy) begin
            pend_q <= pend_nxt;
            if (pend_nxt == '0) begin
                cmd_q <= '0;
            end
        end
    end

    // collision sets the flag, taking precedence over reset-all clearing it
    always_ff @(posedge clk) begin
        if (rst) begin
            err_q <= 1'b0;
        end else if (wr_en && busy) begin
            err_q <= 1'b1;
        end else if (cur_act[B_RSTALL]) begin
            err_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ccs_picker.sv
module ccs_picker
    import chan_cmd_pkg::*;
(
    input  act_mask_t pend,
    output act_mask_t cur_act
);

    always_comb begin
        cur_act = pick_next(pend);
    end

endmodule

// File: rtl/ccs_flags.sv
module ccs_flags
    import chan_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  act_mask_t   cur_act,
    output chan_flags_t flags_q
);

    chan_flags_t nxt;

    always_comb begin
        nxt = flags_q;
        if (cur_act[B_RSTALL] || cur_act[B_CLR]) begin
            nxt = '0;
        end
        if (cur_act[B_RXEN])  nxt.rx_en = 1'b1;
        if (cur_act[B_RXDIS]) nxt.rx_en = 1'b0;
        if (cur_act[B_TXEN])  nxt.tx_en = 1'b1;
        if (cur_act[B_TXDIS]) nxt.tx_en = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            flags_q <= nxt;
        end
    end

endmodule

// File: rtl/chan_cmd_seq.sv
module chan_cmd_seq
    import chan_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    output logic [7:0] cmd_rd,
    output logic       wr_err,
    output logic       tx_enabled,
    output logic       rx_enabled,
    output logic       stb_clr,
    output logic       stb_init,
    output logic       stb_rst_all,
    output logic       stb_tx_en,
    output logic       stb_tx_dis,
    output logic       stb_rx_en,
    output logic       stb_rx_dis
);

    act_mask_t   pend;
    act_mask_t   cur_act;
    chan_flags_t flags;

    ccs_cmd_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cur_act (cur_act),
        .cmd_q   (cmd_rd),
        .pend_q  (pend),
        .err_q   (wr_err)
    );

    ccs_picker u_pick (
        .pend    (pend),
        .cur_act (cur_act)
    );

    ccs_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .cur_act (cur_act),
        .flags_q (flags)
    );

    assign tx_enabled  = flags.tx_en;
    assign rx_enabled  = flags.rx_en;
    assign stb_clr     = cur_act[B_CLR];
    assign stb_init    = cur_act[B_INIT];
    assign stb_rst_all = cur_act[B_RSTALL];
    assign stb_tx_en   = cur_act[B_TXEN];
    assign stb_tx_dis  = cur_act[B_TXDIS];
    assign stb_rx_en   = cur_act[B_RXEN];
    assign stb_rx_dis  = cur_act[B_RXDIS];

endmodule

// File: rtl/ccs_checker.sv
module ccs_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] cmd_rd,
    input logic       wr_err,
    input logic       tx_enabled,
    input logic       rx_enabled,
    input logic       stb_clr,
    input logic       stb_init,
    input logic       stb_rst_all,
    input logic       stb_tx_en,
    input logic       stb_tx_dis,
    input logic       stb_rx_en,
    input logic       stb_rx_dis
);

    logic [6:0] stbs;
    assign stbs = {stb_clr, stb_init, stb_rst_all, stb_tx_en, stb_tx_dis, stb_rx_en, stb_rx_dis};

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) $onehot0(stbs)); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) (cmd_rd == 8'h00) |-> (stbs == 7'd0)); // R4
    AST_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd_rd == 8'h00 && !wr_data[7] && wr_data != 8'h00) |=> (cmd_rd == $past(wr_data))); // R2
    AST_BIT7_DROP: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd_rd == 8'h00 && wr_data[7]) |=> (cmd_rd == 8'h00)); // R3
    AST_RSTALL_DONE: assert property (@(posedge clk) disable iff (rst)
        stb_rst_all |=> (cmd_rd == 8'h00 && !tx_enabled && !rx_enabled)); // R6
    AST_CLR_OFF: assert property (@(posedge clk) disable iff (rst)
        stb_clr |=> (!tx_enabled && !rx_enabled)); // R8
    AST_TX_ON: assert property (@(posedge clk) disable iff (rst) stb_tx_en |=> tx_enabled); // R9
    AST_TX_OFF: assert property (@(posedge clk) disable iff (rst) stb_tx_dis |=> !tx_enabled); // R9
    AST_RX_ON: assert property (@(posedge clk) disable iff (rst) stb_rx_en |=> rx_enabled); // R9
    AST_RX_OFF: assert property (@(posedge clk) disable iff (rst) stb_rx_dis |=> !rx_enabled); // R9
    AST_BUSY_ERR: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd_rd != 8'h00) |=> wr_err); // R10

endmodule

bind chan_cmd_seq ccs_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .cmd_rd      (cmd_rd),
    .wr_err      (wr_err),
    .tx_enabled  (tx_enabled),
    .rx_enabled  (rx_enabled),
    .stb_clr     (stb_clr),
    .stb_init    (stb_init),
    .stb_rst_all (stb_rst_all),
    .stb_tx_en   (stb_tx_en),
    .stb_tx_dis  (stb_tx_dis),
    .stb_rx_en   (stb_rx_en),
    .stb_rx_dis  (stb_rx_dis)
);

// File: tb/tb_chan_cmd_seq.sv
module tb_chan_cmd_seq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic [7:0] cmd_rd;
    logic       wr_err, tx_enabled, rx_enabled;
    logic       stb_clr, stb_init, stb_rst_all, stb_tx_en, stb_tx_dis, stb_rx_en, stb_rx_dis;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit m_tx, m_rx, m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_cmd_seq dut (.*);

    // strobe vector indexed by command bit position
    function automatic logic [6:0] stb_vec();
        return {stb_clr, stb_init, stb_rst_all, stb_tx_en, stb_tx_dis, stb_rx_en, stb_rx_dis};
    endfunction

    // k-th expected action (bit index) for a command, -1 when none
    function automatic int exp_action(input logic [7:0] cmd, input int k);
        int order [7] = '{4, 6, 5, 1, 0, 3, 2};
        logic [6:0] eff;
        int n;
        if (cmd[7]) return -1;
        eff = cmd[6:0];
        if (eff[4]) eff = 7'b0010000;
        n = 0;
        foreach (order[i]) begin
            if (eff[order[i]]) begin
                if (n == k) return order[i];
                n++;
            end
        end
        return -1;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic apply_model(input int a);
        case (a)
            4: begin m_tx = 0; m_rx = 0; m_err = 0; end
            6: begin m_tx = 0; m_rx = 0; end
            1: m_rx = 1;
            0: m_rx = 0;
            3: m_tx = 1;
            2: m_tx = 0;
            default: ;
        endcase
    endtask

    // write cmd; optionally collide with another write at strobe index coll_at (-1 none)
    task automatic issue(input logic [7:0] cmd, input int coll_at, input logic [7:0] cdata);
        int k;
        int a;
        logic [7:0] shown;
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = cmd;
        @(negedge clk);
        wr_en = 1'b0;
        shown = (cmd[7] || cmd == 8'h00) ? 8'h00 : cmd;
        k = 0;
        a = exp_action(cmd, 0);
        while (a >= 0) begin
            chk("R4/R5 strobe", {25'd0, stb_vec()}, 32'd1 << a);
            chk("R2 readback", {24'd0, cmd_rd}, {24'd0, shown});
            apply_model(a);
            if (k == coll_at) begin
                wr_en = 1'b1;
                wr_data = cdata;
                m_err = 1'b1;
            end
            @(negedge clk);
            wr_en = 1'b0;
            k++;
            a = exp_action(cmd, k);
        end
        chk("R7 idle readback", {24'd0, cmd_rd}, 32'd0);
        chk("R3/R4 no strobe idle", {25'd0, stb_vec()}, 32'd0);
        chk("R8/R9 tx flag", {31'd0, tx_enabled}, {31'd0, m_tx});
        chk("R8/R9 rx flag", {31'd0, rx_enabled}, {31'd0, m_rx});
        chk("R6/R10 err flag", {31'd0, wr_err}, {31'd0, m_err});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd4242);
        rst = 1'b1;
        wr_en = 1'b0;
        wr_data = 8'h00;
        m_tx = 0; m_rx = 0; m_err = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 readback", {24'd0, cmd_rd}, 32'd0);
        chk("R1 strobes", {25'd0, stb_vec()}, 32'd0);
        chk("R1 flags", {29'd0, tx_enabled, rx_enabled, wr_err}, 32'd0);

        issue(8'h0A, -1, 8'h00);   // R9 enable both
        issue(8'h0F, -1, 8'h00);   // R9 disable wins both directions
        issue(8'h0A, -1, 8'h00);
        issue(8'h40, -1, 8'h00);   // R8 clear disables
        issue(8'h6A, -1, 8'h00);   // R5 clear, init, rx en, tx en
        issue(8'h80, -1, 8'h00);   // R3 bit 7 dropped, flags kept
        issue(8'hFF, -1, 8'h00);   // R3
        issue(8'h00, -1, 8'h00);   // R2 zero write no effect
        issue(8'h7F, -1, 8'h00);   // R6 reset-all overrides
        issue(8'h2B, 1, 8'h40);    // R10 collision mid-command
        issue(8'h1A, 0, 8'h0A);    // R6/R10 collision on reset-all cycle: err ends set
        issue(8'h10, -1, 8'h00);   // R6 reset-all clears err

        for (int i = 0; i < 400; i++) begin
            logic [7:0] c;
            int n;
            int coll;
            c = 8'($urandom);
            if (($urandom % 8) != 0) c[7] = 1'b0;
            if (($urandom % 3) != 0) c[4] = 1'b0;
            n = 0;
            while (exp_action(c, n) >= 0) n++;
            coll = (n > 0 && ($urandom % 5) == 0) ? int'($urandom % n) : -1;
            issue(c, coll, 8'($urandom));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule